// File: doc/BRIEF.md
# Codec Command Frame Sequencer

This block sits between a host-written command queue and a byte-serial codec control port. Software pushes one or more complete command frames into an internal FIFO while processing is switched off, then raises the enable input. The sequencer then pulls bytes from the FIFO head and forwards them to the codec one byte per valid/ready handshake. It treats the first byte as a header. The low nibble of the header is an opcode, and the opcode sets how many payload bytes follow. The four upper header bits are flags (address convention, read/write, power-up and channel select). The sequencer passes them through unchanged.

Software detects that a command has finished by polling until the FIFO is empty. A one-cycle completion pulse follows the last payload byte of every frame. Opcode 0xF has no defined length. A header carrying it is dropped without being sent, and an error pulse is raised. If the FIFO runs dry inside a frame, the sequencer waits for more bytes. If the enable is removed, the sequencer falls back to expecting a header.

Top module: `cfs_cmd_sequencer`

## Requirements
- R1: After reset the FIFO reports empty, not full, and tx_valid, frame_done and bad_op are all low.
- R2: fifo_full is high when DEPTH bytes are held. A write while full is dropped, and the dropped byte is never sent.
- R3: While proc_en is low, tx_valid stays low and no byte leaves the FIFO.
- R4: The header byte is presented first on tx_data, all 8 bits unchanged. Bits 7..4 are flags (bit 7 address convention, bit 6 read=1/write=0, bit 5 power-up, bit 4 channel) and bits 3..0 are the opcode.
- R5: After the header, exactly N payload bytes are sent, where N depends on the opcode: 0:4, 1:4, 2:2, 3:2, 4:1, 5:1, 6:1, 7:1, 8:2, 9:4, A:8, B:2, C:8, D:4, E:4. Multi-byte values such as the 16-bit gain words of opcodes 2 and B go out in FIFO order, high byte first as written.
- R6: A byte leaves only on a cycle where tx_valid and tx_ready are both high. While tx_ready is low and proc_en stays high, tx_valid and tx_data hold.
- R7: tx_last is high exactly while the final payload byte of a frame is presented. frame_done pulses for one cycle on the cycle after that byte is accepted.
- R8: A header with opcode 0xF is removed from the FIFO without being presented. bad_op pulses for one cycle on the following cycle.
- R9: If the FIFO empties inside a frame, tx_valid drops. The frame continues with the remaining count once bytes arrive.
- R10: Lowering proc_en inside a frame abandons it. The next byte sent after re-enabling is treated as a header.
- R11: Frames are sent strictly in FIFO order, and the byte after a frame's last payload byte is decoded as a new header.
- R12: With proc_en high and tx_ready high, a fully loaded frame drains until fifo_empty rises, which marks completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push wr_data into the command FIFO |
| wr_data | input | 8 | Byte written by software |
| proc_en | input | 1 | Enables command processing |
| tx_ready | input | 1 | Codec accepts the presented byte |
| tx_valid | output | 1 | A byte is presented to the codec |
| tx_data | output | 8 | Presented byte |
| tx_last | output | 1 | Presented byte ends its frame |
| fifo_empty | output | 1 | Command FIFO holds no bytes |
| fifo_full | output | 1 | Command FIFO holds DEPTH bytes |
| frame_done | output | 1 | One-cycle pulse after a frame's last byte is accepted |
| bad_op | output | 1 | One-cycle pulse after an invalid header is dropped |

## Verification
The assertions assume that wr_en, wr_data, proc_en and tx_ready change only between clock edges and are never unknown after reset. They also assume that the codec samples tx_data only when tx_valid is high. The bench drives every input at the falling edge from a single process, so these conditions hold. It exercises stalls, underruns and enable drops only through those legal input sequences, and never forces internal state.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   localparam int BYTE_W = 8;
   localparam int OP_W   = 4;
   localparam int CNT_W  = 4;

   typedef enum logic {
      SEQ_HDR  = 1'b0,
      SEQ_BODY = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic            addr_conv;
      logic            rd_nwr;
      logic            pwr_up;
      logic            chan_sel;
      logic [OP_W-1:0] opcode;
   } hdr_t;

   function automatic logic [CNT_W-1:0] body_len(input logic [OP_W-1:0] op);
      case (op)
         4'h0, 4'h1, 4'h9, 4'hD, 4'hE: body_len = 4'd4;
         4'h2, 4'h3, 4'h8, 4'hB:       body_len = 4'd2;
         4'h4, 4'h5, 4'h6, 4'h7:       body_len = 4'd1;
         4'hA, 4'hC:                   body_len = 4'd8;
         default:                      body_len = 4'd0;
      endcase
   endfunction
endpackage

// File: rtl/cfs_fifo.sv
module cfs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("cfs_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_wr, do_rd;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign head  = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/cfs_len_lut.sv
module cfs_len_lut
   import cfs_pkg::*;
(
   input  logic [OP_W-1:0]  opcode,
   output logic [CNT_W-1:0] len,
   output logic             known
);
   assign len   = body_len(opcode);
   assign known = (len != '0);
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
   import cfs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             proc_en,
   input  logic             head_vld,
   input  logic [CNT_W-1:0] hdr_len,
   input  logic             hdr_known,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic             tx_last,
   output logic             pop,
   output logic             frame_done,
   output logic             bad_op
);
   seq_state_t       state;
   logic [CNT_W-1:0] remain;
   logic             in_body, accept, drop;

   assign in_body  = (state == SEQ_BODY);
   assign tx_valid = proc_en && head_vld && (in_body || hdr_known);
   assign drop     = proc_en && head_vld && !in_body && !hdr_known;
   assign accept   = tx_valid && tx_ready;
   assign pop      = accept || drop;
   assign tx_last  = in_body && (remain == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_HDR;
         remain     <= '0;
         frame_done <= 1'b0;
         bad_op     <= 1'b0;
      end else begin
         frame_done <= accept && tx_last;
         bad_op     <= drop;
         if (!proc_en) begin
            state  <= SEQ_HDR;
            remain <= '0;
         end else if (accept) begin
            if (!in_body) begin
               state  <= SEQ_BODY;
               remain <= hdr_len;
            end else begin
               remain <= remain - 1'b1;
               if (tx_last) state <= SEQ_HDR;
            end
         end
      end
   end
endmodule

// File: rtl/cfs_cmd_sequencer.sv
module cfs_cmd_sequencer
   import cfs_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              proc_en,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_last,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic              frame_done,
   output logic              bad_op
);
   if (DEPTH < 9) begin : g_depth_chk
      $error("cfs_cmd_sequencer: DEPTH must hold the longest frame (9 bytes)");
   end

   logic [BYTE_W-1:0] head;
   hdr_t              hdr;
   logic [CNT_W-1:0]  hdr_len;
   logic              hdr_known, pop;

   assign hdr     = hdr_t'(head);
   assign tx_data = head;

   cfs_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   cfs_len_lut u_lut (
      .opcode (hdr.opcode),
      .len    (hdr_len),
      .known  (hdr_known)
   );

   cfs_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .proc_en    (proc_en),
      .head_vld   (!fifo_empty),
      .hdr_len    (hdr_len),
      .hdr_known  (hdr_known),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_last    (tx_last),
      .pop        (pop),
      .frame_done (frame_done),
      .bad_op     (bad_op)
   );
endmodule

// File: rtl/cfs_cmd_sequencer_chk.sv
module cfs_cmd_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       proc_en,
   input logic       tx_ready,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_last,
   input logic       fifo_empty,
   input logic       fifo_full,
   input logic       frame_done,
   input logic       bad_op
);
   logic leaving;
   assign leaving = (tx_valid && tx_ready) || (proc_en && !fifo_empty && !tx_valid);

   a_r1_no_send_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !tx_valid);

   a_r2_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !leaving) |=> fifo_full);

   a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_en |-> !tx_valid);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (!proc_en || (tx_valid && $stable(tx_data))));

   a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(tx_valid && tx_ready && tx_last));

   a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last && proc_en && !fifo_empty |-> tx_valid);

   a_r8_err_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> $past(proc_en && !fifo_empty && !tx_valid));

   a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bad_op && frame_done));
endmodule

bind cfs_cmd_sequencer cfs_cmd_sequencer_chk u_chk (.*);

// File: tb/tb_cfs_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_cfs_cmd_sequencer;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       proc_en = 1'b0;
   logic       tx_ready = 1'b0;
   logic       tx_valid, tx_last, fifo_empty, fifo_full, frame_done, bad_op;
   logic [7:0] tx_data;

   always #5 clk = ~clk;

   cfs_cmd_sequencer #(.DEPTH(DEPTH)) dut (.*);

   int    n_chk = 0;
   int    n_fail = 0;
   bit    finished = 0;
   string tag = "R1";

   logic [7:0] q[$];
   int         st = 0;
   int         rem = 0;

   function automatic int plen(input logic [3:0] op);
      case (op)
         4'h0, 4'h1, 4'h9, 4'hD, 4'hE: return 4;
         4'h2, 4'h3, 4'h8, 4'hB:       return 2;
         4'h4, 4'h5, 4'h6, 4'h7:       return 1;
         4'hA, 4'hC:                   return 8;
         default:                      return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] d, input logic e, input logic r);
      int sz;
      logic [7:0] hd;
      bit ev, el, acc, drp, e_done, e_err, push_ok;
      @(negedge clk);
      wr_en = w; wr_data = d; proc_en = e; tx_ready = r;
      #1;
      sz = q.size();
      hd = (sz > 0) ? q[0] : 8'h00;
      ev = e && sz > 0 && (st == 1 || hd[3:0] != 4'hF);
      el = (st == 1) && (rem == 1);
      chk(tx_valid === ev, "R6 tx_valid", int'(tx_valid), int'(ev));
      if (ev) begin
         chk(tx_data === hd, "R4 tx_data", int'(tx_data), int'(hd));
         chk(tx_last === el, "R7 tx_last", int'(tx_last), int'(el));
      end
      chk(fifo_empty === (sz == 0), "R12 fifo_empty", int'(fifo_empty), int'(sz == 0));
      chk(fifo_full === (sz == DEPTH), "R2 fifo_full", int'(fifo_full), int'(sz == DEPTH));
      acc = ev && r;
      drp = e && sz > 0 && st == 0 && hd[3:0] == 4'hF;
      e_done = acc && el;
      e_err = drp;
      push_ok = w && sz < DEPTH;
      if (acc || drp) void'(q.pop_front());
      if (push_ok) q.push_back(d);
      if (!e) begin
         st = 0; rem = 0;
      end else if (acc) begin
         if (st == 0) begin
            st = 1; rem = plen(hd[3:0]);
         end else begin
            rem--;
            if (rem == 0) st = 0;
         end
      end
      @(posedge clk);
      #1;
      chk(frame_done === e_done, "R7 frame_done", int'(frame_done), int'(e_done));
      chk(bad_op === e_err, "R8 bad_op", int'(bad_op), int'(e_err));
   endtask

   task automatic load(input logic [7:0] b);
      step(1'b1, b, 1'b0, 1'b0);
   endtask

   task automatic run(input int n, input logic r);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, r);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      tag = "R1";
      chk(fifo_empty === 1'b1, "R1 empty", int'(fifo_empty), 1);
      chk(fifo_full === 1'b0, "R1 full", int'(fifo_full), 0);
      chk(tx_valid === 1'b0, "R1 valid", int'(tx_valid), 0);
      chk(frame_done === 1'b0 && bad_op === 1'b0, "R1 pulses", int'({frame_done, bad_op}), 0);

      tag = "R3";
      load(8'h26); load(8'hC3);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk(fifo_empty === 1'b0, "R3 bytes kept", int'(fifo_empty), 0);

      tag = "R4";
      run(4, 1'b1);

      tag = "R6";
      load(8'h2B); load(8'hAB); load(8'hCD);
      for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1, logic'(i % 3 == 2));
      run(3, 1'b1);

      tag = "R5";
      for (int op = 0; op < 15; op++) begin
         load({4'hA, 4'(op)});
         for (int k = 0; k < plen(4'(op)); k++) load(8'(op * 16 + k + 1));
         run(plen(4'(op)) + 3, 1'b1);
      end

      tag = "R8";
      load(8'hEF); load(8'h24); load(8'h5A);
      run(5, 1'b1);

      tag = "R9";
      load(8'h39); load(8'h01); load(8'h02);
      run(5, 1'b1);
      step(1'b1, 8'h03, 1'b1, 1'b1);
      run(2, 1'b1);
      step(1'b1, 8'h04, 1'b1, 1'b1);
      run(3, 1'b1);

      tag = "R10";
      load(8'h21); load(8'h14); load(8'h24); load(8'h77);
      run(2, 1'b1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      run(6, 1'b1);

      tag = "R2";
      for (int i = 0; i < DEPTH + 2; i++) load((i % 2 == 0) ? 8'h64 : 8'(i));
      chk(fifo_full === 1'b1, "R2 full after fill", int'(fifo_full), 1);

      tag = "R11";
      run(DEPTH + 4, 1'b1);

      tag = "R12";
      load(8'h2C);
      for (int k = 0; k < 8; k++) load(8'(8'hF0 + k));
      run(12, 1'b1);
      chk(fifo_empty === 1'b1, "R12 drained", int'(fifo_empty), 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule